// File: doc/BRIEF.md
# Byte UART with Read-Armed Flag Clearing

This block is a byte-wide serial port that sits on a simple synchronous register bus. Software writes a byte to one shared data address to send it. It reads the same address to collect a received byte. Four registers are reachable through a 2-bit address: control, divisor, status and data. The serial side carries one line out, one line in, and a driver-enable output that a half-duplex transceiver uses for bus turnaround. The frame is fixed: one start bit, eight data bits sent least significant first, and one stop bit.

The status flags are never cleared by writing to them. A flag clears only through a two-step handshake. First, a status read must see the flag set; this arms the clear. Later, the matching access to the data address completes it. The arm survives any amount of unrelated bus traffic. Any data access, however, uses up every arm.

The transmitter is a four-state machine: `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_STOP`.
- `TX_IDLE` goes to `TX_START` when a byte is pending.
- `TX_START` goes to `TX_DATA` at the end of the start bit.
- `TX_DATA` loops once per bit and goes to `TX_STOP` after bit 7.
- `TX_STOP` goes straight to `TX_START` if another byte is pending, and otherwise back to `TX_IDLE`.

The receiver is a four-state machine: `RX_IDLE`, `RX_HUNT`, `RX_DATA`, `RX_STOP`.
- `RX_IDLE` goes to `RX_HUNT` on a low line.
- `RX_HUNT` goes to `RX_DATA` if the line is still low at mid start bit, and otherwise back to `RX_IDLE`.
- `RX_DATA` goes to `RX_STOP` after eight samples.
- `RX_STOP` goes to `RX_IDLE`.
- Clearing the receive enable returns the receiver to `RX_IDLE` from any state.

Top module: `armed_uart`

## Requirements
- R1: Out of reset, the status register (address 2) reads 0x03: bit0 TXE=1, bit1 TC=1, bit2 RXF=0, bit3 OVR=0. The control register (address 0) reads 0. The divisor (address 1) reads 1. The received-byte buffer reads 0. The serial output is high and the driver enable is low.
- R2: Setting the transmit enable (control bit0) on its own never starts a frame. The serial output stays high and the driver enable stays low.
- R3: A write to address 3 while transmit is enabled sends an 8N1 frame, LSB first, with each bit lasting 16 × divisor clocks (a divisor of 0 acts as 1). The driver enable is high for exactly the frame length.
- R4: A status read that sees TXE=1 and TC=1, followed by a data write, clears both TXE and TC. A data write with no such read still sends the byte but leaves TXE and TC at 1.
- R5: TXE rises on the cycle the buffered byte moves into the shifter. A second byte written during a frame keeps TXE at 0 until that byte in turn enters the shifter.
- R6: TC sets, and the driver enable falls, on the same edge that ends a stop bit with no byte pending. Back-to-back frames keep the driver enable high with no gap.
- R7: A read of address 3 returns the last received byte, never the value written there.
- R8: A status read that sees RXF=1, followed by a data read, clears RXF and OVR. A data read with no such read leaves RXF set.
- R9: An arm persists across any number of control and divisor accesses.
- R10: Any data read or write consumes all arms. A later data write or read is therefore unarmed.
- R11: A byte that completes while RXF=1 sets OVR and is discarded; the buffer keeps the older byte.
- R12: A data write is dropped, with no flag change, when transmit is disabled or when a byte is already waiting in the buffer.
- R13: A low pulse on the serial input that ends before mid start bit is rejected, and no byte is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 control, 1 divisor, 2 status, 3 data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as the read strobe |
| ser_rx | input | 1 | Serial input line |
| ser_tx | output | 1 | Serial output line |
| drv_en | output | 1 | Transceiver driver enable, high while a frame is on the line |

## Verification
The assertions assume that each bus access is a one-cycle strobe and that read and write are never raised together. The bench's access tasks keep to this by raising exactly one strobe for one cycle and dropping it at the next falling edge. The assertions also assume the serial input changes no faster than the bit period, apart from the deliberate short glitch. The bench drives the input either from the block's own output through a loopback or from a task that holds each level for a full bit time.

// File: rtl/auart_pkg.sv
package auart_pkg;
    localparam int DW = 8;
    localparam int AW = 2;

    localparam logic [AW-1:0] A_CTRL = 2'd0;
    localparam logic [AW-1:0] A_BAUD = 2'd1;
    localparam logic [AW-1:0] A_STAT = 2'd2;
    localparam logic [AW-1:0] A_DATA = 2'd3;

    localparam int S_TXE = 0;
    localparam int S_TC  = 1;
    localparam int S_RXF = 2;
    localparam int S_OVR = 3;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/auart_tick.sv
module auart_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim = (div == '0) ? '0 : div - DIV_W'(1);
    end

    assign tick = !clr && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/auart_tx.sv
module auart_tx
    import auart_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             req,
    input  logic [DW-1:0]    din,
    output logic             take,
    output logic             done,
    output logic             txd,
    output logic             active
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    tx_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [IW-1:0]  idx_q;
    logic [DW-1:0]  sh_q;
    logic           tick;
    logic           bit_end;
    logic           idle;

    assign idle = (state_q == TX_IDLE);

    auart_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (idle),
        .div  (div),
        .tick (tick)
    );

    assign bit_end = tick && (cnt_q == CW'(OVS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (req) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && idx_q == IW'(DW - 1)) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = req ? TX_START : TX_IDLE;
        endcase
    end

    always_comb begin
        take = 1'b0;
        done = 1'b0;
        txd  = 1'b1;
        unique case (state_q)
            TX_IDLE:  take = req;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            TX_STOP: begin
                take = bit_end && req;
                done = bit_end && !req;
            end
        endcase
        active = !idle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else begin
            if (idle || bit_end)  cnt_q <= '0;
            else if (tick)        cnt_q <= cnt_q + CW'(1);
            if (take) begin
                sh_q  <= din;
                idx_q <= '0;
            end else if (state_q == TX_DATA && bit_end) begin
                sh_q  <= {1'b0, sh_q[DW-1:1]};
                idx_q <= idx_q + IW'(1);
            end
        end
    end
endmodule

// File: rtl/auart_rx.sv
module auart_rx
    import auart_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             rxd,
    output logic             valid,
    output logic [DW-1:0]    dout
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW);

    rx_state_e      state_q, state_d;
    logic [1:0]     sync_q;
    logic           rx_s;
    logic [CW-1:0]  cnt_q;
    logic [IW-1:0]  idx_q;
    logic [DW-1:0]  sh_q;
    logic           tick;
    logic           bit_end;
    logic           mid;
    logic           idle;

    assign rx_s = sync_q[1];
    assign idle = (state_q == RX_IDLE);

    auart_tick #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (idle),
        .div  (div),
        .tick (tick)
    );

    assign bit_end = tick && (cnt_q == CW'(OVS - 1));
    assign mid     = tick && (cnt_q == CW'(OVS / 2 - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE: if (!rx_s) state_d = RX_HUNT;
                RX_HUNT: if (mid) state_d = rx_s ? RX_IDLE : RX_DATA;
                RX_DATA: if (bit_end && idx_q == IW'(DW - 1)) state_d = RX_STOP;
                RX_STOP: if (bit_end) state_d = RX_IDLE;
            endcase
        end
    end

    always_comb begin
        valid = 1'b0;
        unique case (state_q)
            RX_STOP: valid = en && bit_end && rx_s;
            default: valid = 1'b0;
        endcase
        dout = sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            if (state_d != state_q || bit_end) cnt_q <= '0;
            else if (tick)                     cnt_q <= cnt_q + CW'(1);
            if (state_q == RX_HUNT) begin
                idx_q <= '0;
            end else if (state_q == RX_DATA && bit_end) begin
                sh_q  <= {rx_s, sh_q[DW-1:1]};
                idx_q <= idx_q + IW'(1);
            end
        end
    end
endmodule

// File: rtl/armed_uart.sv
module armed_uart
    import auart_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          ser_rx,
    output logic          ser_tx,
    output logic          drv_en
);
    logic             tx_en_q, rx_en_q;
    logic [DIV_W-1:0] div_q;
    logic             txe_q, tc_q, rxf_q, ovr_q;
    logic             arm_txe_q, arm_tc_q, arm_rx_q;
    logic [DW-1:0]    hold_q, rx_buf_q;
    logic             hold_full_q;
    logic             stat_rd, data_rd, data_wr, wr_ok, rx_clr;
    logic             take, done, rx_valid;
    logic [DW-1:0]    rx_byte;
    logic [DW-1:0]    stat;

    assign stat_rd = bus_rd && bus_addr == A_STAT;
    assign data_rd = bus_rd && bus_addr == A_DATA;
    assign data_wr = bus_wr && bus_addr == A_DATA;
    assign wr_ok   = data_wr && tx_en_q && !hold_full_q;
    assign rx_clr  = data_rd && arm_rx_q;

    auart_tx #(.DIV_W(DIV_W), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_q),
        .req   (hold_full_q && tx_en_q),
        .din   (hold_q),
        .take  (take),
        .done  (done),
        .txd   (ser_tx),
        .active(drv_en)
    );

    auart_rx #(.DIV_W(DIV_W), .OVS(OVS)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (rx_en_q),
        .div  (div_q),
        .rxd  (ser_rx),
        .valid(rx_valid),
        .dout (rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
            div_q   <= DIV_W'(1);
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                tx_en_q <= bus_wdata[0];
                rx_en_q <= bus_wdata[1];
            end
            if (bus_addr == A_BAUD) div_q <= DIV_W'(bus_wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_txe_q <= 1'b0;
            arm_tc_q  <= 1'b0;
            arm_rx_q  <= 1'b0;
        end else if (data_rd || data_wr) begin
            arm_txe_q <= 1'b0;
            arm_tc_q  <= 1'b0;
            arm_rx_q  <= 1'b0;
        end else if (stat_rd) begin
            arm_txe_q <= txe_q;
            arm_tc_q  <= tc_q;
            arm_rx_q  <= rxf_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            txe_q       <= 1'b1;
            tc_q        <= 1'b1;
        end else begin
            if (wr_ok) begin
                hold_q      <= bus_wdata;
                hold_full_q <= 1'b1;
            end else if (take) begin
                hold_full_q <= 1'b0;
            end
            if (take)                 txe_q <= 1'b1;
            else if (wr_ok && arm_txe_q) txe_q <= 1'b0;
            if (wr_ok && arm_tc_q)    tc_q <= 1'b0;
            else if (done)            tc_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf_q <= '0;
            rxf_q    <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (rx_clr) begin
                rxf_q <= 1'b0;
                ovr_q <= 1'b0;
            end
            if (rx_valid) begin
                if (rxf_q && !rx_clr) begin
                    ovr_q <= 1'b1;
                end else begin
                    rx_buf_q <= rx_byte;
                    rxf_q    <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        stat        = '0;
        stat[S_TXE] = txe_q;
        stat[S_TC]  = tc_q;
        stat[S_RXF] = rxf_q;
        stat[S_OVR] = ovr_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL: bus_rdata = {6'b0, rx_en_q, tx_en_q};
                A_BAUD: bus_rdata = 8'(div_q);
                A_STAT: bus_rdata = stat;
                A_DATA: bus_rdata = rx_buf_q;
            endcase
        end
    end
endmodule

// File: rtl/armed_uart_chk.sv
module armed_uart_chk
    import auart_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       txe,
    input logic       tc,
    input logic       rxf,
    input logic       ovr,
    input logic       hold_full,
    input logic       de,
    input logic       txd,
    input logic       wr,
    input logic       rd,
    input logic [1:0] addr
);
    // R1: with the driver off the line rests high
    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> txd);

    // R2: a frame starts only from a buffered byte
    a_r2_start_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de) |-> $past(hold_full));

    // R4: TXE only falls from a data write
    a_r4_txe_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txe) |-> $past(wr && addr == A_DATA));

    // R5: TXE low means a byte is waiting
    a_r5_txe_low_byte_waits: assert property (@(posedge clk) disable iff (!rst_n)
        !txe |-> hold_full);

    // R6: the driver drops only into a completed or still-pending state
    a_r6_de_fall_sets_tc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(de) |-> (tc || hold_full));

    // R8: RXF only falls from a data read
    a_r8_rxf_fall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxf) |-> $past(rd && addr == A_DATA));

    // R11: overrun is only possible with a byte still held
    a_r11_ovr_needs_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> rxf);
endmodule

bind armed_uart armed_uart_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txe      (txe_q),
    .tc       (tc_q),
    .rxf      (rxf_q),
    .ovr      (ovr_q),
    .hold_full(hold_full_q),
    .de       (drv_en),
    .txd      (ser_tx),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .addr     (bus_addr)
);

// File: tb/armed_uart_test.sv
`timescale 1ns/1ps
module armed_uart_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] addr;
    logic       rd, wr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       ser_tx, drv_en;
    logic       loop_en, rxd_drv;
    logic       ser_rx;
    int         checks = 0;
    int         errors = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    assign ser_rx = loop_en ? ser_tx : rxd_drv;

    armed_uart uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (addr),
        .bus_rd   (rd),
        .bus_wr   (wr),
        .bus_wdata(wdata),
        .bus_rdata(rdata),
        .ser_rx   (ser_rx),
        .ser_tx   (ser_tx),
        .drv_en   (drv_en)
    );

    // {is_write, addr[1:0], wdata[7:0], expected[7:0], check}
    localparam logic [19:0] VEC [0:6] = '{
        {1'b0, 2'd2, 8'h00, 8'h03, 1'b1},  // R1 status after reset
        {1'b0, 2'd0, 8'h00, 8'h00, 1'b1},  // R1 control after reset
        {1'b0, 2'd1, 8'h00, 8'h01, 1'b1},  // R1 divisor after reset
        {1'b1, 2'd1, 8'h01, 8'h00, 1'b0},  // divisor 1
        {1'b1, 2'd0, 8'h01, 8'h00, 1'b0},  // R2 transmit enable only
        {1'b0, 2'd3, 8'h00, 8'h00, 1'b1},  // R7 receive buffer empty
        {1'b0, 2'd2, 8'h00, 8'h03, 1'b1}   // R2 flags untouched, arms TXE/TC
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wait_de_low();
        int g = 0;
        while (drv_en !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    endtask

    task automatic check_frame(input logic [7:0] b, input int div, input string tag);
        int g = 0;
        while (ser_tx !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
        repeat (8 * div) @(negedge clk);
        chk({tag, " start bit"}, {7'd0, ser_tx}, 8'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (16 * div) @(negedge clk);
            chk({tag, " data bit"}, {7'd0, ser_tx}, {7'd0, b[i]});
        end
        repeat (16 * div) @(negedge clk);
        chk({tag, " stop bit"}, {7'd0, ser_tx}, 8'd1);
    endtask

    task automatic send_rx(input logic [7:0] b);
        rxd_drv = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_drv = b[i];
            repeat (16) @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        bit seen;
        rst_n = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        loop_en = 1'b0; rxd_drv = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 serial out idle", {7'd0, ser_tx}, 8'd1);
        chk("R1 driver enable low", {7'd0, drv_en}, 8'd0);

        for (int k = 0; k < 7; k++) begin
            if (VEC[k][19]) begin
                bus_wr(VEC[k][18:17], VEC[k][16:9]);
            end else begin
                bus_rd(VEC[k][18:17], v);
                if (VEC[k][0]) chk($sformatf("R1/R2/R7 vector %0d", k), v, VEC[k][8:1]);
            end
        end

        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (drv_en || !ser_tx) seen = 1'b1;
            @(negedge clk);
        end
        chk("R2 no frame from enable", {7'd0, seen}, 8'd0);

        // R9: unrelated accesses between the arming read and the write
        loop_en = 1'b1;
        bus_wr(2'd0, 8'h03);
        rd_chk(2'd1, 8'h01, "R9 divisor read between");
        bus_wr(2'd3, 8'hA5);
        rd_chk(2'd2, 8'h00, "R4 R9 armed write clears TXE TC");
        n = 0;
        while (drv_en) begin n++; @(negedge clk); end
        chk("R3 frame length 160 clocks", 8'(n), 8'd160);
        rd_chk(2'd2, 8'h07, "R6 TC set at frame end");
        chk("R6 line idle after frame", {7'd0, ser_tx}, 8'd1);
        rd_chk(2'd3, 8'hA5, "R7 received byte");
        rd_chk(2'd2, 8'h03, "R8 armed read clears RXF");

        // R10: a data read consumes the TX arms just set
        rd_chk(2'd3, 8'hA5, "R10 consuming data read");
        bus_wr(2'd3, 8'h0F);
        rd_chk(2'd2, 8'h03, "R4 R10 unarmed write keeps flags");
        repeat (5) @(negedge clk);
        wait_de_low();
        repeat (5) @(negedge clk);
        rd_chk(2'd3, 8'h0F, "R7 second received byte");
        rd_chk(2'd2, 8'h07, "R8 unarmed read keeps RXF");
        bus_wr(2'd3, 8'h77);
        rd_chk(2'd2, 8'h04, "R4 armed write with RXF held");
        repeat (5) @(negedge clk);
        wait_de_low();
        repeat (5) @(negedge clk);
        rd_chk(2'd2, 8'h0F, "R11 overrun flagged");
        rd_chk(2'd3, 8'h0F, "R11 older byte kept");
        rd_chk(2'd2, 8'h03, "R8 armed read clears RXF and OVR");

        // R5: double buffering
        bus_wr(2'd3, 8'h11);
        rd_chk(2'd2, 8'h00, "R5 TXE low while byte buffered");
        rd_chk(2'd2, 8'h01, "R5 TXE up once byte in shifter");
        bus_wr(2'd3, 8'h22);
        bus_wr(2'd3, 8'h33);
        rd_chk(2'd2, 8'h00, "R5 second byte waiting");
        repeat (40) @(negedge clk);
        rd_chk(2'd2, 8'h00, "R5 TXE held while byte waits");
        repeat (160) @(negedge clk);
        chk("R6 driver stays high between frames", {7'd0, drv_en}, 8'd1);
        rd_chk(2'd2, 8'h05, "R5 TXE up after second transfer");
        wait_de_low();
        rd_chk(2'd2, 8'h0F, "R11 second byte overran");
        repeat (20) @(negedge clk);
        chk("R12 write to full buffer dropped", {7'd0, drv_en}, 8'd0);
        rd_chk(2'd3, 8'h11, "R11 first byte retained");
        rd_chk(2'd2, 8'h03, "R8 flags cleared");

        // R12: transmit disabled
        bus_wr(2'd0, 8'h02);
        rd_chk(2'd2, 8'h03, "R12 arm before dropped write");
        bus_wr(2'd3, 8'h99);
        rd_chk(2'd2, 8'h03, "R12 dropped write keeps flags");
        repeat (30) @(negedge clk);
        chk("R12 no frame while disabled", {7'd0, drv_en}, 8'd0);
        bus_wr(2'd0, 8'h03);
        repeat (30) @(negedge clk);
        chk("R2 R12 dropped byte not sent on enable", {7'd0, drv_en}, 8'd0);

        // R13: start glitch, then a proper frame from the bench
        loop_en = 1'b0;
        rxd_drv = 1'b0;
        repeat (4) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (200) @(negedge clk);
        rd_chk(2'd2, 8'h03, "R13 glitch rejected");
        send_rx(8'hC3);
        repeat (10) @(negedge clk);
        rd_chk(2'd2, 8'h07, "R7 bench frame received");
        rd_chk(2'd3, 8'hC3, "R7 bench frame value");

        // R3: divisor 2 timing
        loop_en = 1'b1;
        rd_chk(2'd2, 8'h03, "R9 arm before divisor change");
        bus_wr(2'd1, 8'h02);
        bus_wr(2'd3, 8'h5A);
        check_frame(8'h5A, 2, "R3 divisor 2");
        wait_de_low();
        rd_chk(2'd2, 8'h07, "R6 TC after slow frame");
        rd_chk(2'd3, 8'h5A, "R3 slow frame looped back");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule